// File: doc/BRIEF.md
# Calendar clock with update cycle

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of week, day of month, month, year and century, and moves the whole calendar forward by one second each time a sub-second phase counter, clocked by single-cycle enables from a 32768 Hz time base, completes a full second. Leap days and month lengths are handled in the carry chain.

Two control bytes steer it. Control A holds a three-bit divider field that runs, stops or holds the phase counter in reset. Control B selects BCD or binary encoding, 12-hour or 24-hour display, and a freeze mode in which software loads new time values without the clock moving under it. A status bit flags the short window just before each update. During that window software should not read the time bytes, because they are about to change. A one-cycle strobe marks each update.

Time is kept internally in binary. The display format is applied at the outputs and undone on writes. Software reaches everything through one write port with a 4-bit address: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century, 8 control A, 9 control B.

Top module: `rtc_core`

## Requirements
- R1: When control B bit 7 (freeze) is 0 and control A bits 6:4 are 010 or lower, the time advances by exactly one second every TICKS_PER_SEC tick enables, and `upd_stb_o` is high for exactly the cycle whose edge applies the advance; otherwise the time does not advance.
- R2: While control A bits 6:5 are both 1 (divider hold), no update occurs and `uip_o` is 0.
- R3: Writing control A while in divider hold with a new bits 6:4 value of 010 or lower, and freeze clear, makes the first update occur after TICKS_PER_SEC/2 ticks.
- R4: `uip_o` is 1 exactly during the last UIP_TICKS tick periods before each update (including the update cycle) and 0 in the cycle after it; `ctrl_a_o` bit 7 shows this status and a written bit 7 is ignored.
- R5: With control B bit 2 at 0, time bytes are read and written as BCD (tens digit in bits 7:4); with bit 2 at 1 they are plain binary.
- R6: With control B bit 1 at 0, the hour byte holds 1 to 12 with bit 7 set for PM hours; hour 0 of the day reads as 12 AM and hour 12 as 12 PM; with bit 1 at 1 the hour byte holds 0 to 23.
- R7: Seconds and minutes roll over after 59, hours after 23, day of week counts 1 to 7, month 1 to 12, year 0 to 99 with a carry into the century byte.
- R8: Day of month rolls over after 30 in April, June, September and November, after 28 in February, or after 29 when year modulo 4 is 0, and after 31 in the other months.
- R9: Writing control B with bit 7 at 1 freezes the time, forces `uip_o` to 0 and stores bit 4 of the written value as 0.
- R10: After reset, control A reads 0x26, control B 0x02, and the time reads 00:00:00, day of week 1, day 1, month 1, year 00, century 20.
- R11: A time byte write while the clock runs restarts the sub-second phase, so the next update comes a full TICKS_PER_SEC ticks later.
- R12: Writes to addresses 10 to 15 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at the 32768 Hz rate |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address (0-7 time bytes, 8 control A, 9 control B) |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| dow_o | output | 8 | Day of week byte |
| dom_o | output | 8 | Day of month byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte |
| cent_o | output | 8 | Century byte |
| ctrl_a_o | output | 8 | Control A with the update-in-progress status in bit 7 |
| ctrl_b_o | output | 8 | Control B |
| uip_o | output | 1 | Update-in-progress status |
| upd_stb_o | output | 1 | One-cycle update strobe |

## Verification
A phase counter that is off by even one tick moves the update strobe and the start of the update window. That shows on `upd_stb_o` and `uip_o` within one second of simulated time, and the per-cycle reference comparison catches it at the exact cycle. A wrong carry in the calendar chain shows on the next time byte at the edge after the strobe. Month-length and leap errors only appear at month ends, so the bench preloads dates one or two seconds before those boundaries. Format faults change no state but corrupt every read, so they are checked by switching the encoding and hour mode on known values.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [4:0] hour;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [3:0] mon;
        logic [6:0] year;
        logic [6:0] cent;
    } rtc_time_t;

    localparam logic [3:0] ADR_SEC  = 4'd0;
    localparam logic [3:0] ADR_MIN  = 4'd1;
    localparam logic [3:0] ADR_HOUR = 4'd2;
    localparam logic [3:0] ADR_DOW  = 4'd3;
    localparam logic [3:0] ADR_DOM  = 4'd4;
    localparam logic [3:0] ADR_MON  = 4'd5;
    localparam logic [3:0] ADR_YEAR = 4'd6;
    localparam logic [3:0] ADR_CENT = 4'd7;
    localparam logic [3:0] ADR_CTLA = 4'd8;
    localparam logic [3:0] ADR_CTLB = 4'd9;

    // raw byte in the display format -> binary value
    function automatic logic [6:0] decode_byte(input logic [7:0] raw, input logic bin);
        logic [7:0] v;
        if (bin) v = raw;
        else     v = ({4'd0, raw[7:4]} * 8'd10) + {4'd0, raw[3:0]};
        return v[6:0];
    endfunction

    // binary value -> byte in the display format
    function automatic logic [7:0] encode_byte(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] year);
        case (mon)
            4'd2:                    return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned UIP_TICKS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic div_run,
    input  logic div_hold,
    input  logic set_mode,
    input  logic load_half,
    input  logic load_zero,
    output logic uip,
    output logic upd_stb
);
    localparam int unsigned PW = $clog2(TICKS_PER_SEC);
    localparam logic [PW-1:0] LAST     = PW'(TICKS_PER_SEC - 1);
    localparam logic [PW-1:0] HALF     = PW'(TICKS_PER_SEC / 2);
    localparam logic [PW-1:0] UIP_FROM = PW'(TICKS_PER_SEC - UIP_TICKS);

    typedef struct packed {
        logic [PW-1:0] phase;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    running;

    always_comb begin
        running = div_run && !set_mode;
        upd_stb = tick && running && (st_q.phase == LAST) && !load_zero && !load_half;
        uip     = running && (st_q.phase >= UIP_FROM);
        st_d    = st_q;
        if (load_half)
            st_d.phase = HALF;
        else if (div_hold || load_zero)
            st_d.phase = '0;
        else if (tick && div_run)
            st_d.phase = (st_q.phase == LAST) ? '0 : st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_UIP_LEADS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |-> uip);                                                      // R4
    AST_UIP_ENDS_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !uip);                                                     // R4

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       bin_mode,
    input  logic       h24,
    output rtc_time_t  t_q
);
    rtc_time_t  t_d;
    logic [6:0] val;
    logic [6:0] hval;
    logic [6:0] hsum;
    logic [4:0] dim;

    always_comb begin
        val  = decode_byte(wr_data, bin_mode);
        hval = decode_byte({1'b0, wr_data[6:0]}, bin_mode) % 7'd12;
        hsum = h24 ? val : hval + (wr_data[7] ? 7'd12 : 7'd0);
        dim  = month_days(t_q.mon, t_q.year);
        t_d  = t_q;
        if (wr_en) begin
            case (wr_sel)
                3'd0: t_d.sec  = val;
                3'd1: t_d.min  = val;
                3'd2: t_d.hour = hsum[4:0];
                3'd3: t_d.dow  = val[2:0];
                3'd4: t_d.dom  = val[4:0];
                3'd5: t_d.mon  = val[3:0];
                3'd6: t_d.year = val;
                default: t_d.cent = val;
            endcase
        end else if (adv) begin
            if (t_q.sec < 7'd59) t_d.sec = t_q.sec + 7'd1;
            else begin
                t_d.sec = '0;
                if (t_q.min < 7'd59) t_d.min = t_q.min + 7'd1;
                else begin
                    t_d.min = '0;
                    if (t_q.hour < 5'd23) t_d.hour = t_q.hour + 5'd1;
                    else begin
                        t_d.hour = '0;
                        t_d.dow  = (t_q.dow >= 3'd7) ? 3'd1 : t_q.dow + 3'd1;
                        if (t_q.dom < dim) t_d.dom = t_q.dom + 5'd1;
                        else begin
                            t_d.dom = 5'd1;
                            if (t_q.mon < 4'd12) t_d.mon = t_q.mon + 4'd1;
                            else begin
                                t_d.mon = 4'd1;
                                if (t_q.year < 7'd99) t_d.year = t_q.year + 7'd1;
                                else begin
                                    t_d.year = '0;
                                    t_d.cent = (t_q.cent >= 7'd99) ? 7'd0 : t_q.cent + 7'd1;
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q      <= '0;
            t_q.dow  <= 3'd1;
            t_q.dom  <= 5'd1;
            t_q.mon  <= 4'd1;
            t_q.cent <= 7'd20;
        end else begin
            t_q <= t_d;
        end
    end

    AST_TIME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_en) |=> $stable(t_q));                                    // R9
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en) |=> (t_q.sec == 7'd0) || (t_q.sec == $past(t_q.sec) + 7'd1)); // R7

endmodule

// File: rtl/rtc_format.sv
module rtc_format
    import rtc_pkg::*;
(
    input  rtc_time_t  t,
    input  logic       bin_mode,
    input  logic       h24,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] dom_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic [7:0] cent_o
);
    logic [4:0] hmod;
    logic [4:0] h12;

    always_comb begin
        hmod   = t.hour % 5'd12;
        h12    = (hmod == 5'd0) ? 5'd12 : hmod;
        sec_o  = encode_byte(t.sec, bin_mode);
        min_o  = encode_byte(t.min, bin_mode);
        hour_o = h24 ? encode_byte({2'b00, t.hour}, bin_mode)
                     : (encode_byte({2'b00, h12}, bin_mode) | {(t.hour >= 5'd12), 7'd0});
        dow_o  = encode_byte({4'd0, t.dow}, bin_mode);
        dom_o  = encode_byte({2'b00, t.dom}, bin_mode);
        mon_o  = encode_byte({3'd0, t.mon}, bin_mode);
        year_o = encode_byte(t.year, bin_mode);
        cent_o = encode_byte(t.cent, bin_mode);
    end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] dom_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic [7:0] cent_o,
    output logic [7:0] ctrl_a_o,
    output logic [7:0] ctrl_b_o,
    output logic       uip_o,
    output logic       upd_stb_o
);
    localparam logic [6:0] CTLA_RST = 7'h26;
    localparam logic [7:0] CTLB_RST = 8'h02;
    localparam int unsigned B_FREEZE = 7;
    localparam int unsigned B_UPDIE  = 4;
    localparam int unsigned B_BIN    = 2;
    localparam int unsigned B_H24    = 1;

    typedef struct packed {
        logic [6:0] a;
        logic [7:0] b;
    } ctrl_t;

    ctrl_t     ctl_d, ctl_q;
    logic      wr_time, wr_a, wr_b;
    logic      div_run, div_hold, set_mode, load_half, load_zero;
    rtc_time_t t_q;

    always_comb begin
        wr_time   = wr_en && (wr_addr <= ADR_CENT);
        wr_a      = wr_en && (wr_addr == ADR_CTLA);
        wr_b      = wr_en && (wr_addr == ADR_CTLB);
        div_run   = ctl_q.a[6:4] <= 3'b010;
        div_hold  = ctl_q.a[6:5] == 2'b11;
        set_mode  = ctl_q.b[B_FREEZE];
        load_half = wr_a && div_hold && (wr_data[6:4] <= 3'b010) && !set_mode;
        load_zero = wr_time && div_run && !set_mode;
        ctl_d     = ctl_q;
        if (wr_a) ctl_d.a = wr_data[6:0];
        if (wr_b) begin
            ctl_d.b = wr_data;
            if (wr_data[B_FREEZE]) ctl_d.b[B_UPDIE] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.a <= CTLA_RST;
            ctl_q.b <= CTLB_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rtc_divider #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_TICKS     (UIP_TICKS)
    ) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_32k),
        .div_run   (div_run),
        .div_hold  (div_hold),
        .set_mode  (set_mode),
        .load_half (load_half),
        .load_zero (load_zero),
        .uip       (uip_o),
        .upd_stb   (upd_stb_o)
    );

    rtc_calendar i_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (upd_stb_o),
        .wr_en    (wr_time),
        .wr_sel   (wr_addr[2:0]),
        .wr_data  (wr_data),
        .bin_mode (ctl_q.b[B_BIN]),
        .h24      (ctl_q.b[B_H24]),
        .t_q      (t_q)
    );

    rtc_format i_fmt (
        .t        (t_q),
        .bin_mode (ctl_q.b[B_BIN]),
        .h24      (ctl_q.b[B_H24]),
        .sec_o    (sec_o),
        .min_o    (min_o),
        .hour_o   (hour_o),
        .dow_o    (dow_o),
        .dom_o    (dom_o),
        .mon_o    (mon_o),
        .year_o   (year_o),
        .cent_o   (cent_o)
    );

    assign ctrl_a_o = {uip_o, ctl_q.a};
    assign ctrl_b_o = ctl_q.b;

    AST_FREEZE_DROPS_UPDIE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.b[B_FREEZE] |-> !ctl_q.b[B_UPDIE]);                              // R9
    AST_FREEZE_NO_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.b[B_FREEZE] |-> (!uip_o && !upd_stb_o));                         // R9
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.a[6:5] == 2'b11) |-> (!uip_o && !upd_stb_o));                   // R2

endmodule

// File: tb/test_rtc_core.sv
module test_rtc_core;
    localparam int T = 64;
    localparam int U = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic tick_en = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o, cent_o;
    logic [7:0] ctrl_a_o, ctrl_b_o;
    logic uip_o, upd_stb_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // reference model state
    int m_sec, m_min, m_hour, m_dow, m_dom, m_mon, m_year, m_cent, m_a, m_b, m_ph;

    rtc_core #(.TICKS_PER_SEC(T), .UIP_TICKS(U)) i_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .dom_o(dom_o), .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o),
        .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o), .uip_o(uip_o), .upd_stb_o(upd_stb_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        #1;
        tick = tick_en && !tick;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic int dec(input int raw, input int b);
        if (b & 4) return raw;
        return (raw >> 4) * 10 + (raw & 15);
    endfunction

    function automatic int enc(input int v, input int b);
        if (b & 4) return v;
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int enc_hour(input int h, input int b);
        int h12;
        if (b & 2) return enc(h, b);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return enc(h12, b) | ((h >= 12) ? 'h80 : 0);
    endfunction

    function automatic bit m_running();
        return (((m_a >> 4) & 7) <= 2) && ((m_b & 'h80) == 0);
    endfunction

    // behavioural reference, stepped on every rising edge
    always @(posedge clk) begin : model
        bit run, hold, twr, upd, rel;
        int nph, v, s, mi, h, dw, dd, mo, y, c;
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_dom = 1; m_mon = 1;
            m_year = 0; m_cent = 20; m_a = 'h26; m_b = 'h02; m_ph = 0;
        end else begin
            run  = m_running();
            hold = ((m_a >> 5) & 3) == 3;
            twr  = wr_en && (wr_addr < 8);
            upd  = tick && run && (m_ph == T - 1) && !twr;
            rel  = wr_en && (wr_addr == 8) && hold && (((wr_data >> 4) & 7) <= 2) && ((m_b & 'h80) == 0);
            nph  = m_ph;
            if (rel) nph = T / 2;
            else if (hold) nph = 0;
            else if (twr && run) nph = 0;
            else if (tick && (((m_a >> 4) & 7) <= 2)) nph = (m_ph + 1) % T;
            s = m_sec; mi = m_min; h = m_hour; dw = m_dow; dd = m_dom; mo = m_mon; y = m_year; c = m_cent;
            if (twr) begin
                v = dec(int'(wr_data), m_b);
                case (wr_addr)
                    0: s = v;
                    1: mi = v;
                    2: if (m_b & 2) h = v;
                       else h = (dec(int'(wr_data) & 'h7f, m_b) % 12) + ((wr_data[7]) ? 12 : 0);
                    3: dw = v;
                    4: dd = v;
                    5: mo = v;
                    6: y = v;
                    default: c = v;
                endcase
            end else if (upd) begin
                s++;
                if (s >= 60) begin
                    s = 0; mi++;
                    if (mi >= 60) begin
                        mi = 0; h++;
                        if (h >= 24) begin
                            h = 0;
                            dw = (dw >= 7) ? 1 : dw + 1;
                            dd++;
                            if (dd > dim(mo, y)) begin
                                dd = 1; mo++;
                                if (mo > 12) begin
                                    mo = 1; y++;
                                    if (y >= 100) begin y = 0; c = (c + 1) % 100; end
                                end
                            end
                        end
                    end
                end
            end
            if (wr_en && wr_addr == 8) m_a = int'(wr_data) & 'h7f;
            if (wr_en && wr_addr == 9) m_b = (wr_data[7]) ? (int'(wr_data) & 'hef) : int'(wr_data);
            m_ph = nph;
            m_sec = s; m_min = mi; m_hour = h; m_dow = dw; m_dom = dd; m_mon = mo; m_year = y; m_cent = c;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        bit run, e_uip, e_upd;
        if (rst_n && cmp_on) begin
            run   = m_running();
            e_uip = run && (m_ph >= T - U);
            e_upd = tick && run && (m_ph == T - 1) && !(wr_en && wr_addr < 8);
            chk("R1", "upd_stb", int'(upd_stb_o), int'(e_upd));
            chk("R4", "uip", int'(uip_o), int'(e_uip));
            chk("R4", "ctrl_a", int'(ctrl_a_o), m_a | (e_uip ? 'h80 : 0));
            chk("R9", "ctrl_b", int'(ctrl_b_o), m_b);
            chk("R7", "sec", int'(sec_o), enc(m_sec, m_b));
            chk("R7", "min", int'(min_o), enc(m_min, m_b));
            chk("R6", "hour", int'(hour_o), enc_hour(m_hour, m_b));
            chk("R7", "dow", int'(dow_o), enc(m_dow, m_b));
            chk("R8", "dom", int'(dom_o), enc(m_dom, m_b));
            chk("R7", "mon", int'(mon_o), enc(m_mon, m_b));
            chk("R7", "year", int'(year_o), enc(m_year, m_b));
            chk("R7", "cent", int'(cent_o), enc(m_cent, m_b));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired: actual %0d cycles expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // counts tick enables up to and including the update cycle
    task automatic wait_upd(output int ticks);
        ticks = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (tick) ticks++;
            if (upd_stb_o) break;
        end
    endtask

    task automatic set_time(input logic [7:0] cen, input logic [7:0] yr, input logic [7:0] mo,
                            input logic [7:0] dd, input logic [7:0] dw, input logic [7:0] hr,
                            input logic [7:0] mi, input logic [7:0] se);
        wr(4'd7, cen); wr(4'd6, yr); wr(4'd5, mo); wr(4'd4, dd);
        wr(4'd3, dw); wr(4'd2, hr); wr(4'd1, mi); wr(4'd0, se);
    endtask

    initial begin
        int n;
        logic [7:0] snap_sec, snap_b, snap_dom;
        bit quiet;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset values
        chk("R10", "ctrl_a", int'(ctrl_a_o), 'h26);
        chk("R10", "ctrl_b", int'(ctrl_b_o), 'h02);
        chk("R10", "sec", int'(sec_o), 'h00);
        chk("R10", "hour", int'(hour_o), 'h00);
        chk("R10", "dom", int'(dom_o), 'h01);
        chk("R10", "cent", int'(cent_o), 'h20);
        chk("R10", "uip", int'(uip_o), 0);
        cmp_on = 1'b1;
        tick_en = 1'b1;

        // R1: one second per T ticks, seconds byte steps by one
        wait_upd(n);
        wait_upd(n);
        chk("R1", "ticks between updates", n, T);
        @(negedge clk);
        chk("R1", "sec after two updates", int'(sec_o), 'h02);

        // R11 and R8 leap day, R7 day-of-week wrap
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
        wait_upd(n);
        chk("R11", "ticks after time write", n, T);
        @(negedge clk);
        chk("R7", "sec 58->59", int'(sec_o), 'h59);
        wait_upd(n);
        @(negedge clk);
        chk("R8", "leap Feb 28 -> 29", int'(dom_o), 'h29);
        chk("R7", "hour wrap", int'(hour_o), 'h00);
        chk("R7", "dow 7 -> 1", int'(dow_o), 'h01);

        // R8: non-leap February
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        wait_upd(n);
        @(negedge clk);
        chk("R8", "non-leap Feb 28 -> Mar 1 dom", int'(dom_o), 'h01);
        chk("R8", "non-leap Feb 28 -> Mar 1 mon", int'(mon_o), 'h03);

        // R8: 30-day month
        set_time(8'h20, 8'h25, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
        wait_upd(n);
        @(negedge clk);
        chk("R8", "Apr 30 -> May 1", int'(mon_o), 'h05);

        // R7: year and century carry
        set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        wait_upd(n);
        @(negedge clk);
        chk("R7", "year 99 -> 00", int'(year_o), 'h00);
        chk("R7", "century 20 -> 21", int'(cent_o), 'h21);
        chk("R7", "month 12 -> 1", int'(mon_o), 'h01);

        // R5: binary encoding
        wr(4'd9, 8'h06);
        wr(4'd0, 8'h2D);
        @(negedge clk);
        chk("R5", "binary sec", int'(sec_o), 'h2D);
        wr(4'd9, 8'h02);
        @(negedge clk);
        chk("R5", "bcd sec", int'(sec_o), 'h45);

        // R6: 12-hour mode
        wr(4'd2, 8'h00);
        wr(4'd9, 8'h00);
        @(negedge clk);
        chk("R6", "midnight as 12 AM", int'(hour_o), 'h12);
        wr(4'd2, 8'h81);
        @(negedge clk);
        chk("R6", "1 PM", int'(hour_o), 'h81);
        wr(4'd2, 8'h92);
        @(negedge clk);
        chk("R6", "noon", int'(hour_o), 'h92);
        wr(4'd9, 8'h02);
        @(negedge clk);
        chk("R6", "noon in 24h", int'(hour_o), 'h12);

        // R9: freeze
        wr(4'd9, 8'h92);
        @(negedge clk);
        chk("R9", "update enable dropped", int'(ctrl_b_o), 'h82);
        snap_sec = sec_o;
        quiet = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (upd_stb_o || uip_o) quiet = 1'b0;
        end
        chk("R9", "no update or uip while frozen", int'(quiet), 1);
        chk("R9", "sec frozen", int'(sec_o), int'(snap_sec));
        wr(4'd9, 8'h02);

        // R2 / R3: divider hold and release
        wr(4'd8, 8'h66);
        snap_sec = sec_o;
        quiet = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (upd_stb_o || uip_o) quiet = 1'b0;
        end
        chk("R2", "quiet in divider hold", int'(quiet), 1);
        chk("R2", "sec held", int'(sec_o), int'(snap_sec));
        wr(4'd8, 8'h26);
        wait_upd(n);
        chk("R3", "ticks to first update after release", n, T / 2);

        // R4: update window length and read-only status bit
        wr(4'd8, 8'hA6);
        @(negedge clk);
        chk("R4", "status bit not writable", int'(ctrl_a_o), 'h26);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (tick && uip_o) n++;
            if (upd_stb_o) break;
        end
        chk("R4", "uip at update", int'(uip_o), 1);
        chk("R4", "ticks with uip high", n, U);
        @(negedge clk);
        chk("R4", "uip low after update", int'(uip_o), 0);

        // R12: unused addresses
        wr(4'd0, 8'h10);
        snap_sec = sec_o; snap_b = ctrl_b_o; snap_dom = dom_o;
        wr(4'hC, 8'h55);
        wr(4'hF, 8'hFF);
        @(negedge clk);
        chk("R12", "sec unchanged", int'(sec_o), int'(snap_sec));
        chk("R12", "ctrl_b unchanged", int'(ctrl_b_o), int'(snap_b));
        chk("R12", "dom unchanged", int'(dom_o), int'(snap_dom));

        repeat (20) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule